// File: doc/BRIEF.md
# Pipelined Integer Divide and Square-Root Core

This block computes either an integer quotient with remainder or an integer square root with remainder. It is a fully pipelined datapath with a fixed latency, so it can accept a new operation on every clock cycle. A two-bit operation code picks the function.

The work is split into three kinds of stage:
- **Setup stage.** Takes operand magnitudes and records the sign and overflow decisions.
- **Digit stages.** A chain of `ceil(W/K)` identical stages. Each one resolves `K` result bits by restoring trial subtraction, which is radix `2^K`.
- **Final stage.** Applies the sign fixes and forces the special results for a zero divisor and for signed overflow.

A valid flag travels beside each operation. Data registers load only when their stage holds a valid operation, so idle cycles leave the datapath quiet. Code zero selects square root. A bus that idles at all zeros therefore produces a zero root and a zero remainder, and no divide activity starts.

Top module: `divsq_core`

## Requirements
- R1: Operation code 0 selects square root, and an all-zero input word (code 0, A = 0, B = 0) yields result 0 and remainder 0.
- R2: Operation code 1 is unsigned division: result = floor(A/B) and remainder = A - result*B, for B not zero.
- R3: In square-root mode, result = floor(sqrt(A)) with A unsigned, and remainder = A - result^2. Operand B is ignored.
- R4: For code 1, 2 or 3 with B = 0, the result has every bit set and the remainder equals A.
- R5: Operation code 2 is two's-complement signed division. The quotient truncates toward zero and the remainder carries the sign of the dividend.
- R6: In signed division, the most negative value divided by -1 returns the most negative value as the result and 0 as the remainder.
- R7: out_valid rises exactly ceil(W/K)+2 clock cycles after the cycle in which in_valid was sampled high. Operations issued on consecutive cycles emerge on consecutive cycles, in order.
- R8: A cycle with in_valid low changes neither out_result nor out_remainder, whatever values in_op, in_a and in_b carry.
- R9: Operation code 3 behaves exactly as code 1.
- R10: A synchronous active-high reset drives out_valid, out_result and out_remainder to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 2 | 0 square root, 1 unsigned divide, 2 signed divide, 3 unsigned divide |
| in_a | input | W | Dividend or radicand |
| in_b | input | W | Divisor (ignored for square root) |
| out_valid | output | 1 | Result present on the outputs |
| out_result | output | W | Quotient or root |
| out_remainder | output | W | Remainder |

## Verification
With the default W = 32 and K = 4, each result is due 10 clock edges after the edge that samples its inputs. That is one setup register, eight digit registers and one output register. The bench drives inputs on falling edges and counts falling edges from the drive. For each single operation it checks that out_valid is still low one cycle before the due cycle and high in the due cycle, and it reads the values only then. For a back-to-back stream, the item issued on falling edge j is checked on falling edge j + 10, which confirms both throughput and ordering.

// File: rtl/divsq_pkg.sv
package divsq_pkg;

  typedef enum logic [1:0] {
    OP_SQRT     = 2'd0,
    OP_UDIV     = 2'd1,
    OP_SDIV     = 2'd2,
    OP_UDIV_ALT = 2'd3
  } op_e;

  // Control word that rides with each operation through the pipe
  typedef struct packed {
    op_e  op;
    logic neg_q;   // negate quotient in final stage
    logic neg_r;   // negate remainder in final stage
    logic ovf;     // signed most-negative / -1 case
  } ctl_t;

endpackage

// File: rtl/divsq_setup.sv
module divsq_setup
  import divsq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [1:0]   op_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         v_out,
  output ctl_t         ctl_out,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] dsr_out
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  op_e          op;
  logic         sgn;
  logic [W-1:0] mag_a, mag_b;
  ctl_t         ctl_n;

  assign op  = op_e'(op_in);
  assign sgn = (op == OP_SDIV);

  always_comb begin
    mag_a = (sgn && a[W-1]) ? (~a + 1'b1) : a;
    if (op == OP_SQRT)
      mag_b = '0;
    else
      mag_b = (sgn && b[W-1]) ? (~b + 1'b1) : b;
    ctl_n.op    = op;
    ctl_n.neg_q = sgn && (a[W-1] ^ b[W-1]);
    ctl_n.neg_r = sgn && a[W-1];
    ctl_n.ovf   = sgn && (a == MOST_NEG) && (b == '1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out   <= 1'b0;
      ctl_out <= '0;
      rem_out <= '0;
      dsr_out <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        ctl_out <= ctl_n;
        rem_out <= mag_a;
        dsr_out <= mag_b;
      end
    end
  end

  // Magnitudes stay put while no operation enters
  p_setup_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(rem_out) && $stable(dsr_out));

endmodule

// File: rtl/divsq_digit.sv
module divsq_digit
  import divsq_pkg::*;
#(
  parameter int W   = 32,
  parameter int K   = 4,
  parameter int IDX = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  ctl_t         ctl_in,
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] dsr_in,
  output logic         v_out,
  output ctl_t         ctl_out,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] dsr_out
);

  localparam int TW = 2 * W + 2;
  localparam int HI = W - 1 - IDX * K;
  localparam int LO = (HI - K + 1 < 0) ? 0 : (HI - K + 1);

  logic [W-1:0] rem_n, acc_n;

  always_comb begin
    int pos;
    logic [TW-1:0] trial;
    rem_n = rem_in;
    acc_n = acc_in;
    trial = '0;
    for (int bi = 0; bi < K; bi++) begin
      pos = HI - bi;
      if (pos >= 0) begin
        if (ctl_in.op == OP_SQRT)
          trial = (TW'(acc_n) << (pos + 1)) | (TW'(1) << (2 * pos));
        else
          trial = TW'(dsr_in) << pos;
        if (TW'(rem_n) >= trial) begin
          rem_n = W'(TW'(rem_n) - trial);
          acc_n = acc_n | (W'(1) << pos);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out   <= 1'b0;
      ctl_out <= '0;
      rem_out <= '0;
      acc_out <= '0;
      dsr_out <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        ctl_out <= ctl_in;
        rem_out <= rem_n;
        acc_out <= acc_n;
        dsr_out <= dsr_in;
      end
    end
  end

  p_digit_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(rem_out) && $stable(acc_out));

  // Restoring invariant: partial remainder below divisor scaled to the lowest resolved bit
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (v_out && ctl_out.op != OP_SQRT && dsr_out != '0)
      |-> (TW'(rem_out) < (TW'(dsr_out) << LO)));

endmodule

// File: rtl/divsq_final.sv
module divsq_final
  import divsq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  ctl_t         ctl_in,
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] dsr_in,
  output logic         v_out,
  output logic [W-1:0] result,
  output logic [W-1:0] rem
);

  localparam int           HR       = (W + 1) / 2;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] q_n, r_n;
  logic         dz;
  op_e          op_q;

  always_comb begin
    q_n = ctl_in.neg_q ? (~acc_in + 1'b1) : acc_in;
    r_n = ctl_in.neg_r ? (~rem_in + 1'b1) : rem_in;
    dz  = (ctl_in.op != OP_SQRT) && (dsr_in == '0);
    if (dz)
      q_n = '1;
    if (ctl_in.ovf) begin
      q_n = MOST_NEG;
      r_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out  <= 1'b0;
      result <= '0;
      rem    <= '0;
      op_q   <= OP_SQRT;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        result <= q_n;
        rem    <= r_n;
        op_q   <= ctl_in.op;
      end
    end
  end

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(result) && $stable(rem));

  // Root fits in half the width and remainder never exceeds twice the root
  p_root_range_r3: assert property (@(posedge clk) disable iff (rst)
    (v_out && op_q == OP_SQRT)
      |-> ((result >> HR) == '0) && ({1'b0, rem} <= {result, 1'b0}));

endmodule

// File: rtl/divsq_core.sv
module divsq_core
  import divsq_pkg::*;
#(
  parameter int W = 32,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic [W-1:0] out_remainder
);

  localparam int NST = (W + K - 1) / K;

  logic         v_s   [0:NST];
  ctl_t         ctl_s [0:NST];
  logic [W-1:0] rem_s [0:NST];
  logic [W-1:0] acc_s [0:NST];
  logic [W-1:0] dsr_s [0:NST];

  divsq_setup #(.W(W)) u_setup (
    .clk    (clk),
    .rst    (rst),
    .v_in   (in_valid),
    .op_in  (in_op),
    .a      (in_a),
    .b      (in_b),
    .v_out  (v_s[0]),
    .ctl_out(ctl_s[0]),
    .rem_out(rem_s[0]),
    .dsr_out(dsr_s[0])
  );

  assign acc_s[0] = '0;

  for (genvar i = 0; i < NST; i++) begin : g_dig
    divsq_digit #(.W(W), .K(K), .IDX(i)) u_dig (
      .clk    (clk),
      .rst    (rst),
      .v_in   (v_s[i]),
      .ctl_in (ctl_s[i]),
      .rem_in (rem_s[i]),
      .acc_in (acc_s[i]),
      .dsr_in (dsr_s[i]),
      .v_out  (v_s[i+1]),
      .ctl_out(ctl_s[i+1]),
      .rem_out(rem_s[i+1]),
      .acc_out(acc_s[i+1]),
      .dsr_out(dsr_s[i+1])
    );
  end

  divsq_final #(.W(W)) u_final (
    .clk   (clk),
    .rst   (rst),
    .v_in  (v_s[NST]),
    .ctl_in(ctl_s[NST]),
    .rem_in(rem_s[NST]),
    .acc_in(acc_s[NST]),
    .dsr_in(dsr_s[NST]),
    .v_out (out_valid),
    .result(out_result),
    .rem   (out_remainder)
  );

  // Output valid can only appear if the last digit stage held an operation
  p_valid_chain_r7: assert property (@(posedge clk) disable iff (rst)
    !v_s[NST] |=> !out_valid);

endmodule

// File: tb/divsq_core_test.sv
module divsq_core_test;

  localparam int W   = 32;
  localparam int K   = 4;
  localparam int LAT = (W + K - 1) / K + 2;
  localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   in_op = 2'd0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_result, out_remainder;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [W-1:0] last_q, last_r;

  always #5 clk = ~clk;

  divsq_core #(.W(W), .K(K)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_result(out_result), .out_remainder(out_remainder)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb;
    logic [W-1:0] root;
    if (op == 2'd0) begin
      root = '0;
      for (int i = (W + 1) / 2 - 1; i >= 0; i--) begin
        longint c;
        c = longint'(root | (W'(1) << i));
        if (c * c <= longint'({32'b0, a})) root = root | (W'(1) << i);
      end
      q = root;
      r = a - root * root;
    end else if (b == '0) begin
      q = '1;
      r = a;
    end else if (op == 2'd2) begin
      if (a == MNEG && b == '1) begin
        q = MNEG;
        r = '0;
      end else begin
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q = W'(sa / sb);
        r = W'(sa % sb);
      end
    end else begin
      q = a / b;
      r = a % b;
    end
  endfunction

  task automatic run_one(input string req, input logic [1:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    logic [W-1:0] eq, er;
    model(op, a, b, eq, er);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    for (int c = 1; c <= LAT; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (c == LAT - 1) chk("R7 not yet valid", {63'b0, out_valid}, 64'd0);
    end
    chk("R7 valid at latency", {63'b0, out_valid}, 64'd1);
    chk({req, " result"}, {32'b0, out_result}, {32'b0, eq});
    chk({req, " remainder"}, {32'b0, out_remainder}, {32'b0, er});
    last_q = eq;
    last_r = er;
  endtask

  task automatic t_reset;
    chk("R10 valid after reset", {63'b0, out_valid}, 64'd0);
    chk("R10 result after reset", {32'b0, out_result}, 64'd0);
    chk("R10 remainder after reset", {32'b0, out_remainder}, 64'd0);
  endtask

  task automatic t_idle_zero;
    run_one("R1", 2'd0, '0, '0);
  endtask

  task automatic t_udiv;
    run_one("R2", 2'd1, 32'd100, 32'd7);
    run_one("R2", 2'd1, 32'hFFFF_FFFF, 32'd1);
    run_one("R2", 2'd1, 32'h1234_5678, 32'h0000_1000);
    run_one("R2", 2'd1, 32'd5, 32'd9);
    run_one("R2", 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
  endtask

  task automatic t_sqrt;
    run_one("R3", 2'd0, 32'hFFFF_FFFF, 32'h1234_0000);
    run_one("R3", 2'd0, 32'd144, 32'd0);
    run_one("R3", 2'd0, 32'd145, 32'd3);
    run_one("R3", 2'd0, 32'd2, 32'd0);
    run_one("R3", 2'd0, 32'h4000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_divzero;
    run_one("R4 unsigned", 2'd1, 32'd1234, 32'd0);
    run_one("R4 signed", 2'd2, -32'sd5, 32'd0);
    run_one("R4 alt", 2'd3, 32'hDEAD_BEEF, 32'd0);
  endtask

  task automatic t_sdiv;
    run_one("R5", 2'd2, -32'sd7, 32'd2);
    run_one("R5", 2'd2, 32'd7, -32'sd2);
    run_one("R5", 2'd2, -32'sd7, -32'sd2);
    run_one("R5", 2'd2, MNEG, 32'd1);
    run_one("R5", 2'd2, 32'd1000, -32'sd1000);
  endtask

  task automatic t_ovf;
    run_one("R6", 2'd2, MNEG, 32'hFFFF_FFFF);
  endtask

  task automatic t_alt;
    run_one("R9", 2'd3, 32'd1000, 32'd33);
    run_one("R9", 2'd3, 32'h8000_0001, 32'd3);
  endtask

  task automatic t_stream;
    localparam int N = 12;
    logic [1:0]   sop [N];
    logic [W-1:0] sa  [N];
    logic [W-1:0] sb  [N];
    logic [W-1:0] eq  [N];
    logic [W-1:0] er  [N];
    for (int i = 0; i < N; i++) begin
      sop[i] = 2'(i % 4);
      sa[i]  = 32'h9E37_79B9 * (i + 3);
      sb[i]  = (i == 5) ? 32'd0 : (32'h0001_0003 * (i + 1)) >> (i % 7);
      model(sop[i], sa[i], sb[i], eq[i], er[i]);
    end
    @(negedge clk);
    for (int c = 0; c <= N + LAT; c++) begin
      if (c < N) begin
        in_valid = 1'b1; in_op = sop[c]; in_a = sa[c]; in_b = sb[c];
      end else begin
        in_valid = 1'b0;
      end
      if (c >= LAT && c - LAT < N) begin
        chk("R7 stream valid", {63'b0, out_valid}, 64'd1);
        chk("R7 stream result", {32'b0, out_result}, {32'b0, eq[c-LAT]});
        chk("R7 stream remainder", {32'b0, out_remainder}, {32'b0, er[c-LAT]});
      end
      @(negedge clk);
    end
    last_q = eq[N-1];
    last_r = er[N-1];
  endtask

  task automatic t_hold;
    for (int c = 0; c < LAT + 3; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op = 2'(c);
      in_a = 32'hA5A5_0000 + c;
      in_b = 32'h0000_0100 + c;
    end
    chk("R8 valid stays low", {63'b0, out_valid}, 64'd0);
    chk("R8 result held", {32'b0, out_result}, {32'b0, last_q});
    chk("R8 remainder held", {32'b0, out_remainder}, {32'b0, last_r});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_zero();
    t_udiv();
    t_sqrt();
    t_divzero();
    t_sdiv();
    t_ovf();
    t_alt();
    t_stream();
    t_hold();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule